// File: doc/BRIEF.md
# Start-of-Frame Interrupt Generator

This block raises one start-of-frame interrupt per bus frame, so that isochronous transfers can be scheduled off a steady frame beat. It takes a one-cycle pulse for each correctly received start-of-frame packet. A frame timer restarts on every such pulse. If a packet is corrupted and never arrives, the timer runs past its threshold. When synthetic frame generation is enabled, the block then inserts a substitute event, so the frame still gets its interrupt.

Each event, real or substitute, sets a latched interrupt request that software clears. It also drives a one-cycle event strobe and a flag telling whether the latest event was synthetic. A sequencer with three named states tracks frame lock. IDLE means no frame reference exists yet, so the timer is stopped. LOCKED means the last event was a real packet. COAST means the last event was synthetic.

The transitions are these. A real packet moves any state to LOCKED. A timeout moves LOCKED or COAST to COAST while generation is enabled. A timeout with generation disabled moves LOCKED or COAST to IDLE. With no input activity the state holds. The timeout threshold is the parameter `TIMEOUT_CYCLES`, in clock cycles, and is set slightly above one 1 ms frame.

Top module: `sof_irq_gen`

## Requirements
- R1: After reset, sof_irq, sof_pulse and sof_synth are 0 and the sequencer is in IDLE with the timer stopped.
- R2: sof_rx high at a clock edge makes sof_pulse high for the following cycle, sets sof_irq at that edge, and drives sof_synth to 0.
- R3: sof_irq stays 1 until irq_clr is sampled high with no event in the same cycle; it is then 0 from the next cycle.
- R4: When an event and irq_clr occur in the same cycle, sof_irq is 1 afterwards.
- R5: With synth_en = 1 and the sequencer in LOCKED or COAST, a gap of TIMEOUT_CYCLES cycles without sof_rx after the last event produces a synthetic event: sof_pulse high and sof_synth = 1, exactly TIMEOUT_CYCLES cycles after the previous strobe.
- R6: While packets stay missing and synth_en = 1, synthetic events repeat once every TIMEOUT_CYCLES cycles.
- R7: With synth_en = 0, a timeout produces no event and returns the sequencer to IDLE. Setting synth_en afterwards creates no event until a real packet arrives.
- R8: In IDLE, no event is produced without sof_rx, whatever synth_en is.
- R9: A real packet that arrives in the very cycle the timer expires gives a single event with sof_synth = 0, and the next synthetic event comes TIMEOUT_CYCLES cycles later.
- R10: A real packet at any point of the frame restarts the timer, so the next synthetic event comes TIMEOUT_CYCLES cycles after that packet.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sof_rx | input | 1 | One-cycle pulse per correctly received start-of-frame packet |
| synth_en | input | 1 | Enables synthetic events on frame timeout |
| irq_clr | input | 1 | Software clear of the interrupt request |
| sof_irq | output | 1 | Latched start-of-frame interrupt request |
| sof_pulse | output | 1 | One-cycle strobe per frame event |
| sof_synth | output | 1 | 1 when the latest event was synthetic |

## Verification
The hardest situation to reach is a real packet that lands in exactly the cycle the timer expires. The only way to observe it is through the spacing of the strobes. The bench shortens TIMEOUT_CYCLES to 8, counts the cycles from the last synthetic strobe, and fires sof_rx on the cycle the timer expires. It then checks that the cycle produces a single strobe marked real, and that the following strobe comes a full period later. Falling back to IDLE is reached in the same way: the bench withholds packets with generation disabled, then re-enables generation and confirms that the line stays quiet.

// File: rtl/sofg_pkg.sv
package sofg_pkg;
    typedef enum logic [1:0] {
        SOFG_IDLE   = 2'd0,
        SOFG_LOCKED = 2'd1,
        SOFG_COAST  = 2'd2
    } sofg_state_t;
endpackage

// File: rtl/sofg_frame_timer.sv
module sofg_frame_timer #(
    parameter int unsigned LIMIT = 48500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic restart,
    output logic expire
);
    localparam int unsigned CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt;

    assign expire = run && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (restart || expire || !run) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // R6
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !restart && !expire) |=> (cnt == $past(cnt) + 1'b1));

    // R10
    restart_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (cnt == '0));
endmodule

// File: rtl/sofg_seq.sv
module sofg_seq
    import sofg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sof_rx,
    input  logic synth_en,
    input  logic expire,
    output logic run,
    output logic evt,
    output logic pulse,
    output logic synth
);
    sofg_state_t state, state_nx;

    logic synth_evt;
    assign synth_evt = expire && synth_en && !sof_rx;
    assign evt       = sof_rx || synth_evt;
    assign run       = (state != SOFG_IDLE);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SOFG_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            SOFG_IDLE: begin
                if (sof_rx) state_nx = SOFG_LOCKED;
            end
            SOFG_LOCKED, SOFG_COAST: begin
                if (sof_rx)        state_nx = SOFG_LOCKED;
                else if (expire)   state_nx = synth_en ? SOFG_COAST : SOFG_IDLE;
            end
            default: state_nx = SOFG_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pulse <= 1'b0;
            synth <= 1'b0;
        end else begin
            pulse <= evt;
            if (evt) synth <= synth_evt;
        end
    end

    // R2
    real_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sof_rx |=> (pulse && !synth));

    // R5
    synth_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse && synth) |-> $past(synth_en));

    // R8
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SOFG_IDLE && !sof_rx) |=> !pulse);

    // R7
    disabled_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && !synth_en && !sof_rx) |=> (state == SOFG_IDLE && !pulse));
endmodule

// File: rtl/sofg_req_latch.sv
module sofg_req_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic req
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req <= 1'b0;
        end else if (set) begin
            req <= 1'b1;
        end else if (clr) begin
            req <= 1'b0;
        end
    end

    // R3
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !clr) |=> req);

    // R3
    req_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !set) |=> !req);

    // R4
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set && clr) |=> req);
endmodule

// File: rtl/sof_irq_gen.sv
module sof_irq_gen #(
    parameter int unsigned TIMEOUT_CYCLES = 48500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sof_rx,
    input  logic synth_en,
    input  logic irq_clr,
    output logic sof_irq,
    output logic sof_pulse,
    output logic sof_synth
);
    logic run;
    logic expire;
    logic evt;

    sofg_frame_timer #(.LIMIT(TIMEOUT_CYCLES)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .restart (sof_rx),
        .expire  (expire)
    );

    sofg_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .sof_rx   (sof_rx),
        .synth_en (synth_en),
        .expire   (expire),
        .run      (run),
        .evt      (evt),
        .pulse    (sof_pulse),
        .synth    (sof_synth)
    );

    sofg_req_latch u_req (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (evt),
        .clr   (irq_clr),
        .req   (sof_irq)
    );

    // R2
    pulse_sets_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sof_pulse |-> sof_irq);
endmodule

// File: tb/sim_sof_irq_gen.sv
module sim_sof_irq_gen;
    localparam int unsigned T = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sof_rx = 1'b0;
    logic synth_en = 1'b0;
    logic irq_clr = 1'b0;
    logic sof_irq, sof_pulse, sof_synth;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    sof_irq_gen #(.TIMEOUT_CYCLES(T)) u0 (
        .clk(clk), .rst_n(rst_n), .sof_rx(sof_rx), .synth_en(synth_en),
        .irq_clr(irq_clr), .sof_irq(sof_irq), .sof_pulse(sof_pulse),
        .sof_synth(sof_synth)
    );

    // row: {rx, en, clr, exp_irq, exp_pulse, exp_synth}
    localparam int NV = 23;
    localparam logic [5:0] VEC [NV] = '{
        6'b000_000, // R1 idle after reset
        6'b100_110, // R2 real packet
        6'b000_100, // R3 held
        6'b001_000, // R3 cleared
        6'b101_110, // R4 set beats clear
        6'b001_000,
        6'b000_000, 6'b000_000, 6'b000_000,
        6'b000_000, 6'b000_000, 6'b000_000,
        6'b000_000, // R7 timeout while disabled: no event
        6'b010_000, 6'b010_000, 6'b010_000, 6'b010_000, 6'b010_000, // R7 idle after drop
        6'b010_000, 6'b010_000, 6'b010_000, 6'b010_000, 6'b010_000
    };

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic step(input logic rx, input logic en, input logic clr);
        @(negedge clk);
        sof_rx = rx; synth_en = en; irq_clr = clr;
        @(posedge clk);
        #1;
    endtask

    task automatic expect_evt(input string tag, input logic p, input logic s);
        check(sof_pulse === p, tag, "sof_pulse", int'(sof_pulse), int'(p));
        if (p) check(sof_synth === s, tag, "sof_synth", int'(sof_synth), int'(s));
    endtask

    task automatic quiet(input int n, input logic en, input string tag);
        for (int i = 0; i < n; i++) begin
            step(1'b0, en, 1'b0);
            expect_evt(tag, 1'b0, 1'b0);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #2000000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1
        check(sof_irq === 1'b0, "R1", "sof_irq", int'(sof_irq), 0);
        check(sof_pulse === 1'b0, "R1", "sof_pulse", int'(sof_pulse), 0);
        check(sof_synth === 1'b0, "R1", "sof_synth", int'(sof_synth), 0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int v = 0; v < NV; v++) begin
            step(VEC[v][5], VEC[v][4], VEC[v][3]);
            check(sof_irq === VEC[v][2], "R2/R3/R4 vec", "sof_irq", int'(sof_irq), int'(VEC[v][2]));
            check(sof_pulse === VEC[v][1], "R2/R7/R8 vec", "sof_pulse", int'(sof_pulse), int'(VEC[v][1]));
            check(sof_synth === VEC[v][0], "R2 vec", "sof_synth", int'(sof_synth), int'(VEC[v][0]));
        end

        // R8: idle with generation on, no packets
        quiet(2 * T, 1'b1, "R8");

        // R5 and R6: lock then lose packets
        step(1'b1, 1'b1, 1'b0);
        expect_evt("R2", 1'b1, 1'b0);
        quiet(T - 1, 1'b1, "R5");
        step(1'b0, 1'b1, 1'b0);
        expect_evt("R5", 1'b1, 1'b1);
        quiet(T - 1, 1'b1, "R6");
        step(1'b0, 1'b1, 1'b0);
        expect_evt("R6", 1'b1, 1'b1);

        // R10: real packet mid-frame restarts timer
        quiet(3, 1'b1, "R10");
        step(1'b1, 1'b1, 1'b0);
        expect_evt("R10", 1'b1, 1'b0);
        quiet(T - 1, 1'b1, "R10");
        step(1'b0, 1'b1, 1'b0);
        expect_evt("R10", 1'b1, 1'b1);

        // R9: real packet exactly on expiry
        quiet(T - 1, 1'b1, "R9");
        step(1'b1, 1'b1, 1'b0);
        expect_evt("R9", 1'b1, 1'b0);
        quiet(T - 1, 1'b1, "R9");
        step(1'b0, 1'b1, 1'b0);
        expect_evt("R9", 1'b1, 1'b1);

        // R7: disable while coasting, then re-enable
        quiet(T, 1'b0, "R7");
        quiet(2 * T, 1'b1, "R7");

        // R3: clear after all that
        step(1'b0, 1'b1, 1'b1);
        check(sof_irq === 1'b0, "R3", "sof_irq", int'(sof_irq), 0);

        // R1: reset mid-operation
        step(1'b1, 1'b1, 1'b0);
        @(negedge clk);
        rst_n = 1'b0; sof_rx = 1'b0;
        @(posedge clk);
        #1;
        check(sof_irq === 1'b0, "R1", "sof_irq", int'(sof_irq), 0);
        check(sof_pulse === 1'b0, "R1", "sof_pulse", int'(sof_pulse), 0);
        check(sof_synth === 1'b0, "R1", "sof_synth", int'(sof_synth), 0);
        @(negedge clk);
        rst_n = 1'b1;
        quiet(2 * T, 1'b1, "R1");

        finish_run();
    end
endmodule